// File: doc/BRIEF.md
# Grouped Pin Toggle Interrupt Controller

This block watches a bank of general-purpose input pins and turns any level change on them into one of a small number of grouped interrupt requests. Pins are bundled into groups of eight in ascending order, with the last group holding only the leftover pins. With the defaults there are 27 pins in four groups: pins 0–7, 8–15, 16–23 and 24–26. Each pin first passes through a synchronizer. A change counts only when the pin's own mask bit is one and its group's enable bit is one. A change that counts latches a pending flag for that group.

Software reaches the block through a simple register bus with a combinational read port. Through this bus it can read the pending flags and clear them by writing ones. It can also set the per-group enables and program one mask register per group. An interrupt controller takes a request through a one-hot acknowledge input, and that input clears the matching flag. A group's request line is high only while its flag, its group enable and the global interrupt enable are all one.

Top module: `pin_toggle_irq`

## Requirements
- R1: Pins 0–7 set flag bit 0, pins 8–15 set flag bit 1, pins 16–23 set flag bit 2 and pins 24–26 set flag bit 3. A mask register at address 2+g controls group g, and bit i of that register belongs to pin 8g+i.
- R2: A rising or a falling change on a pin sets its group flag only when the pin's mask bit is one and the group enable bit (register 1, bit g) is one. If the group enable is zero, the change is dropped.
- R3: `irq_req[g]` is high exactly when flag g, enable g and `irq_global_en` are all one.
- R4: Writing to address 0 clears each flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R5: A one on `irq_ack[g]` during a clock edge clears flag g.
- R6: Flag bits 7..4, enable bits 7..4 and bits 7..3 of the group-3 mask register always read as zero.
- R7: After reset, every flag, enable and mask bit is zero and no request is raised.
- R8: A pin whose mask bit is zero never sets a flag, however often it toggles.
- R9: If a qualifying change and a clear (a one-write or an acknowledge) act on the same flag at the same edge, the flag ends up set.
- R10: The register map is: flags at 0, enables at 1, group masks at 2–5. Reads of addresses 6 and 7 return zero.
- R11: A pin change driven before clock edge 1 shows in the flag after edge 3 and not after edge 2. This delay is two synchronizer stages plus the compare stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 27 | Asynchronous pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_ack | input | 4 | One-hot acknowledge, clears the selected flag |
| irq_req | output | 4 | Per-group interrupt requests |

## Verification
The bench checks that both edge directions latch a flag, and that a masked-off pin or a disabled group leaves the flags untouched. A design that tested only rising edges, or that ignored the mask or the enable, would show a wrong flag value on readback. It lines up a fresh change with an acknowledge at the same edge; a design where the clear wins would lose the flag. It also probes the short last group, the reserved bits, the unmapped addresses and the exact three-edge delay. A mis-sliced group, a reserved bit left writable or an extra or missing pipeline stage would each return a wrong value in a known cycle.

// File: rtl/pti_pkg.sv
`timescale 1ns/1ps
package pti_pkg;
  localparam int ADDR_FLAGS = 0;
  localparam int ADDR_GEN   = 1;
  localparam int ADDR_MASK0 = 2;

  function automatic int grp_count(input int npins, input int gw);
    return (npins + gw - 1) / gw;
  endfunction

  function automatic int grp_lo(input int g, input int gw);
    return g * gw;
  endfunction

  function automatic int grp_width(input int g, input int npins, input int gw);
    int rem;
    rem = npins - g * gw;
    return (rem < gw) ? rem : gw;
  endfunction

  // a new event beats a same-cycle clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/pti_sync.sv
`timescale 1ns/1ps
module pti_sync #(
  parameter int NPINS  = 27,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] toggles
);
  logic [STAGES-1:0][NPINS-1:0] stage_q;
  logic [NPINS-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q[0] <= pins_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign toggles = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pti_regs.sv
`timescale 1ns/1ps
module pti_regs #(
  parameter int NPINS = 27,
  parameter int GW    = 8,
  parameter int NG    = 4,
  parameter int AW    = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [NG-1:0]    flags,
  output logic [DW-1:0]    bus_rdata,
  output logic [NPINS-1:0] mask,
  output logic [NG-1:0]    grp_en,
  output logic [NG-1:0]    flag_w1c
);
  import pti_pkg::*;

  logic [DW-1:0] grp_rd [NG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_en <= '0;
    else if (bus_we && bus_addr == AW'(ADDR_GEN)) grp_en <= bus_wdata[NG-1:0];
  end

  for (genvar g = 0; g < NG; g++) begin : g_mask
    localparam int LO = grp_lo(g, GW);
    localparam int W  = grp_width(g, NPINS, GW);
    logic [W-1:0] m_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '0;
      else if (bus_we && bus_addr == AW'(ADDR_MASK0 + g)) m_q <= bus_wdata[W-1:0];
    end
    assign mask[LO +: W] = m_q;
    assign grp_rd[g]     = DW'(m_q);
  end

  assign flag_w1c = (bus_we && bus_addr == AW'(ADDR_FLAGS)) ? bus_wdata[NG-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_FLAGS)) bus_rdata = DW'(flags);
    else if (bus_addr == AW'(ADDR_GEN)) bus_rdata = DW'(grp_en);
    else begin
      for (int g = 0; g < NG; g++)
        if (bus_addr == AW'(ADDR_MASK0 + g)) bus_rdata = grp_rd[g];
    end
  end
endmodule

// File: rtl/pti_flags.sv
`timescale 1ns/1ps
module pti_flags #(
  parameter int NPINS = 27,
  parameter int GW    = 8,
  parameter int NG    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] toggles,
  input  logic [NPINS-1:0] mask,
  input  logic [NG-1:0]    grp_en,
  input  logic [NG-1:0]    w1c,
  input  logic [NG-1:0]    ack,
  output logic [NG-1:0]    flags,
  output logic [NG-1:0]    set_evt,
  output logic [NG-1:0]    clr_evt
);
  import pti_pkg::*;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = grp_lo(g, GW);
    localparam int W  = grp_width(g, NPINS, GW);
    assign set_evt[g] = grp_en[g] & (|(toggles[LO +: W] & mask[LO +: W]));
    assign clr_evt[g] = w1c[g] | ack[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else begin
      for (int g = 0; g < NG; g++)
        flags[g] <= flag_next(flags[g], set_evt[g], clr_evt[g]);
    end
  end
endmodule

// File: rtl/pin_toggle_irq.sv
`timescale 1ns/1ps
module pin_toggle_irq #(
  parameter int NPINS       = 27,
  parameter int GW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3,
  parameter int DW          = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPINS-1:0]             pins_in,
  input  logic                         bus_we,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DW-1:0]                bus_wdata,
  output logic [DW-1:0]                bus_rdata,
  input  logic                         irq_global_en,
  input  logic [(NPINS+GW-1)/GW-1:0]   irq_ack,
  output logic [(NPINS+GW-1)/GW-1:0]   irq_req
);
  localparam int NG = pti_pkg::grp_count(NPINS, GW);

  logic [NPINS-1:0] toggles;
  logic [NPINS-1:0] mask;
  logic [NG-1:0]    grp_en;
  logic [NG-1:0]    flags;
  logic [NG-1:0]    set_evt;
  logic [NG-1:0]    clr_evt;
  logic [NG-1:0]    flag_w1c;

  pti_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .toggles(toggles)
  );

  pti_regs #(.NPINS(NPINS), .GW(GW), .NG(NG), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .flags(flags), .bus_rdata(bus_rdata),
    .mask(mask), .grp_en(grp_en), .flag_w1c(flag_w1c)
  );

  pti_flags #(.NPINS(NPINS), .GW(GW), .NG(NG)) u_flags (
    .clk(clk), .rst_n(rst_n), .toggles(toggles), .mask(mask),
    .grp_en(grp_en), .w1c(flag_w1c), .ack(irq_ack), .flags(flags),
    .set_evt(set_evt), .clr_evt(clr_evt)
  );

  assign irq_req = flags & grp_en & {NG{irq_global_en}};
endmodule

// File: rtl/pin_toggle_irq_chk.sv
`timescale 1ns/1ps
module pin_toggle_irq_chk #(
  parameter int NG = 4,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NG-1:0] flags,
  input logic [NG-1:0] set_evt,
  input logic [NG-1:0] clr_evt,
  input logic [NG-1:0] irq_req,
  input logic          irq_global_en,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata
);
  // R3
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~flags) == '0);

  // R3
  irq_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> irq_global_en);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_evt) |=> ((flags & $past(clr_evt & ~set_evt)) == '0));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt == '0) |=> ((flags & ~$past(flags)) == '0));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt == '0) |=> ((~flags & $past(flags)) == '0));

  // R6
  flag_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (bus_rdata[DW-1:NG] == '0));
endmodule

bind pin_toggle_irq pin_toggle_irq_chk #(.NG(NG), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .set_evt(set_evt),
  .clr_evt(clr_evt), .irq_req(irq_req), .irq_global_en(irq_global_en),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/pin_toggle_irq_test.sv
`timescale 1ns/1ps
module pin_toggle_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [26:0] pins = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        gie = 1'b0;
  logic [3:0]  ack = '0;
  logic [3:0]  irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // bench model
  logic [3:0] m_flags = '0, m_en = '0;

  typedef struct {
    logic [2:0] a;
    logic [7:0] d;
    logic [3:0] q;
    string      tag;
  } item_t;
  item_t sb[$];

  pin_toggle_irq uut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_global_en(gie),
    .irq_ack(ack), .irq_req(irq)
  );

  always #5 clk = ~clk;

  // monitor: pops expected items and compares away from the edge
  initial begin
    forever begin
      wait (sb.size() != 0);
      #2;
      begin
        item_t it;
        it = sb.pop_front();
        n_checks++;
        if (rdata !== it.d || irq !== it.q) begin
          n_errors++;
          $display("FAIL %s addr=%0d rdata=%h exp=%h irq=%b exp=%b",
                   it.tag, it.a, rdata, it.d, irq, it.q);
        end
      end
    end
  end

  // driver: push an expected read, wait for the monitor, end at a negedge
  task automatic chk(input string tag, input logic [2:0] a, input logic [7:0] d);
    item_t it;
    addr = a;
    it.a = a; it.d = d; it.q = m_flags & m_en & {4{gie}}; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic flip(input int p);
    pins[p] = ~pins[p];
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 / R10: everything zero after reset, unmapped reads zero
    for (int a = 0; a < 8; a++) chk("R7_reset", 3'(a), 8'h00);

    wr(3'd1, 8'hFF); m_en = 4'hF;
    chk("R6_en_reserved", 3'd1, 8'h0F);
    wr(3'd2, 8'h01);
    chk("R10_mask0_map", 3'd2, 8'h01);
    wr(3'd5, 8'hFF);
    chk("R6_mask3_reserved", 3'd5, 8'h07);
    wr(3'd3, 8'h80);
    wr(3'd4, 8'h01);
    chk("R10_mask2_map", 3'd4, 8'h01);

    // R11: rising edge on pin 0, flag after third edge only
    pins[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11_not_yet", 3'd0, 8'h00);
    m_flags = 4'h1;
    chk("R11_R2_rise", 3'd0, 8'h01);
    gie = 1'b1;
    chk("R3_irq_on", 3'd0, 8'h01);

    wr(3'd0, 8'hF0);
    chk("R4_zero_no_effect", 3'd0, 8'h01);
    wr(3'd0, 8'h01); m_flags = 4'h0;
    chk("R4_w1c", 3'd0, 8'h00);

    flip(0); m_flags = 4'h1;
    chk("R2_fall", 3'd0, 8'h01);
    ack = 4'b0001;
    @(negedge clk);
    ack = 4'b0000; m_flags = 4'h0;
    chk("R5_ack", 3'd0, 8'h00);

    // R8: unmasked pins toggle freely
    for (int p = 1; p < 8; p++) flip(p);
    flip(9); flip(25 - 1 + 0 == 24 ? 17 : 17);
    chk("R8_masked_off", 3'd0, 8'h00);

    // R1: group mapping, incl. the short last group
    flip(15); m_flags = 4'h2;
    chk("R1_grp1", 3'd0, 8'h02);
    flip(16); m_flags = 4'h6;
    chk("R1_grp2", 3'd0, 8'h06);
    flip(26); m_flags = 4'hE;
    chk("R1_grp3", 3'd0, 8'h0E);
    wr(3'd0, 8'hFF); m_flags = 4'h0;
    chk("R4_w1c_all", 3'd0, 8'h00);
    flip(24); m_flags = 4'h8;
    chk("R1_grp3_pin24", 3'd0, 8'h08);
    wr(3'd0, 8'h08); m_flags = 4'h0;

    // R2: group enable off drops the change
    wr(3'd1, 8'h0D); m_en = 4'hD;
    flip(15);
    chk("R2_grp_disabled", 3'd0, 8'h00);
    wr(3'd1, 8'h0F); m_en = 4'hF;
    chk("R2_no_late_set", 3'd0, 8'h00);

    // R3: flag set but enable off -> no request
    flip(0); m_flags = 4'h1;
    wr(3'd1, 8'h0E); m_en = 4'hE;
    chk("R3_en_gates", 3'd0, 8'h01);
    wr(3'd1, 8'h0F); m_en = 4'hF;

    // R9: new change meets acknowledge at the same edge
    pins[0] = ~pins[0];
    repeat (2) @(negedge clk);
    ack = 4'b0001;
    @(negedge clk);
    ack = 4'b0000;
    chk("R9_set_wins", 3'd0, 8'h01);
    ack = 4'b0001;
    @(negedge clk);
    ack = 4'b0000; m_flags = 4'h0;
    chk("R5_ack_after", 3'd0, 8'h00);
    gie = 1'b0;
    chk("R10_unmapped6", 3'd6, 8'h00);
    chk("R10_unmapped7", 3'd7, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule